// File: doc/BRIEF.md
# SPI Slave Pause (Hold) Controller

This block sits between the pins of an SPI slave and its command engine. It watches an active-low pause pin, the serial clock and the active-low chip select. From them it derives an internal pause state. While paused, serial clock edges are withheld from the command engine and the serial output driver is disabled. The engine's own state is untouched, so a transfer continues from the exact bit where it stopped once the pause ends.

The pause pin is evaluated against the serial clock level. When the clock is low, a change of the pause pin takes effect at once. When the clock is high, the change waits until the clock next goes low. Deselecting the device always clears the pause. If the device is deselected during a pause, a one-cycle abort strobe tells the engine that the transaction in progress has ended.

All pins are synchronised into the system clock domain through a parameterised flip-flop chain. Every output is registered. The pause level present when the device is first selected follows the same clock-level rule.

Top module: `spi_hold_ctrl`

## Requirements
- R1: With chip select low (0) and the serial clock low (0), driving the pause pin low (0) sets `hold_active` to 1 within SYNC_STAGES+1 system clock cycles.
- R2: With chip select low and the serial clock high (1), a low pause pin leaves `hold_active` at 0 until the serial clock returns low; it then becomes 1.
- R3: Once paused, a high (1) pause pin clears `hold_active` while the serial clock is low. While the serial clock stays high, `hold_active` remains 1 until the clock next goes low.
- R4: `so_oe` is 1 only when the device is selected and not paused. It is 0 in every cycle where `hold_active` is 1, whatever the serial clock does.
- R5: A high chip select clears `hold_active` whatever the pause pin does. When chip select rises during a pause, `hold_abort` pulses for exactly one cycle. A deselect outside a pause gives no pulse.
- R6: When chip select falls while the pause pin is already low, the pause begins at once if the serial clock is low. If the clock is high, the pause waits for the clock to go low.
- R7: Each serial clock rising and falling edge seen while not paused yields exactly one one-cycle pulse on `sck_rise` or `sck_fall`. Edges seen while paused yield none.
- R8: A serial clock edge at which the pause begins or ends is not passed on, so `sck_rise` and `sck_fall` are 0 in the cycle where `hold_active` changes.
- R9: A synchronous reset (`rst` = 1) drives `hold_active`, `so_oe`, `sck_rise`, `sck_fall` and `hold_abort` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Pause pin, active low, asynchronous |
| sck | input | 1 | SPI serial clock pin, asynchronous |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| hold_active | output | 1 | 1 while the transfer is paused |
| so_oe | output | 1 | 1 when the serial output may be driven |
| sck_rise | output | 1 | Qualified serial clock rising-edge strobe |
| sck_fall | output | 1 | Qualified serial clock falling-edge strobe |
| hold_abort | output | 1 | One-cycle strobe: deselected while paused |

## Verification
The bench builds the block with SYNC_STAGES = 3, one stage deeper than the default. Every pin change therefore crosses a longer chain before the pause decision. This shows that the clock-level rule and the edge masking depend only on the order in which the synchronised levels change, not on a fixed latency. The bench holds each pin level for eight system cycles, which covers the deeper chain. It exercises the entry and exit orderings while the serial clock is high and while it is low, selection with the pause pin already low, and deselection both during and outside a pause.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  // Order of the synchronised pin bundle
  localparam int PIN_CS   = 2;
  localparam int PIN_HOLD = 1;
  localparam int PIN_SCK  = 0;
  localparam int PIN_W    = 3;

  // Idle pin levels: deselected, not paused, clock low
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b110;

  typedef struct packed {
    logic cs_n;
    logic hold_n;
    logic sck;
  } pins_t;
endpackage

// File: rtl/hold_pin_sync.sv
module hold_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hold_edge_det.sv
module hold_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  output logic rise,
  output logic fall
);
  logic sck_d;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign rise = sck_s & ~sck_d;
  assign fall = ~sck_s & sck_d;
endmodule

// File: rtl/hold_state.sv
module hold_state (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic hold_n_s,
  input  logic sck_s,
  input  logic rise,
  input  logic fall,
  output logic hold_q,
  output logic so_oe_q,
  output logic rise_q,
  output logic fall_q,
  output logic abort_q
);
  logic hold_nx;
  logic quiet;

  // The pause level follows the pin only while the clock is low.
  // While the clock is high the current state is kept.
  always_comb begin
    if (cs_n_s)     hold_nx = 1'b0;
    else if (sck_s) hold_nx = hold_q;
    else            hold_nx = ~hold_n_s;
  end

  // An edge is passed on only if no pause is active on either side of it
  assign quiet = ~hold_q & ~hold_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      so_oe_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      hold_q  <= hold_nx;
      so_oe_q <= ~cs_n_s & ~hold_nx;
      rise_q  <= rise & quiet;
      fall_q  <= fall & quiet;
      abort_q <= hold_q & cs_n_s;
    end
  end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_n,
  input  logic sck,
  input  logic cs_n,
  output logic hold_active,
  output logic so_oe,
  output logic sck_rise,
  output logic sck_fall,
  output logic hold_abort
);
  import spi_hold_pkg::*;

  pins_t raw_pins;
  logic [PIN_W-1:0] pins_s;
  logic rise_c;
  logic fall_c;

  assign raw_pins = '{cs_n: cs_n, hold_n: hold_n, sck: sck};

  hold_pin_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) i_sync (
    .clk(clk), .rst(rst), .d(raw_pins), .q(pins_s)
  );

  hold_edge_det i_edge (
    .clk(clk), .rst(rst), .sck_s(pins_s[PIN_SCK]),
    .rise(rise_c), .fall(fall_c)
  );

  hold_state i_state (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[PIN_CS]), .hold_n_s(pins_s[PIN_HOLD]), .sck_s(pins_s[PIN_SCK]),
    .rise(rise_c), .fall(fall_c),
    .hold_q(hold_active), .so_oe_q(so_oe),
    .rise_q(sck_rise), .fall_q(sck_fall), .abort_q(hold_abort)
  );
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic hold_active,
  input logic so_oe,
  input logic sck_rise,
  input logic sck_fall,
  input logic hold_abort
);
  assert_oe_off_in_hold_R4: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !so_oe);

  assert_no_edge_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> (!sck_rise && !sck_fall));

  assert_single_edge_kind_R7: assert property (@(posedge clk) disable iff (rst)
    !(sck_rise && sck_fall));

  assert_no_edge_at_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_active) |-> (!sck_rise && !sck_fall));

  assert_no_edge_at_exit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_active) |-> (!sck_rise && !sck_fall));

  assert_abort_after_hold_R5: assert property (@(posedge clk) disable iff (rst)
    hold_abort |-> ($past(hold_active) && !hold_active));

  assert_abort_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    hold_abort |=> !hold_abort);
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .hold_active(hold_active), .so_oe(so_oe),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .hold_abort(hold_abort)
);

// File: tb/test_spi_hold_ctrl.sv
module test_spi_hold_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_n = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic hold_active, so_oe, sck_rise, sck_fall, hold_abort;

  int checks = 0;
  int errors = 0;
  int n_rise = 0, n_fall = 0, n_abort = 0;

  always #2.5 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(3)) i_spi_hold_ctrl (
    .clk(clk), .rst(rst), .hold_n(hold_n), .sck(sck), .cs_n(cs_n),
    .hold_active(hold_active), .so_oe(so_oe),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .hold_abort(hold_abort)
  );

  always @(posedge clk) begin
    if (rst) begin
      n_rise <= 0; n_fall <= 0; n_abort <= 0;
    end else begin
      n_rise  <= n_rise  + int'(sck_rise);
      n_fall  <= n_fall  + int'(sck_fall);
      n_abort <= n_abort + int'(hold_abort);
    end
  end

  // {cs_n, hold_n, sck, exp_hold, exp_oe, req[3:0]}, walked in order
  localparam int NV = 17;
  localparam logic [8:0] VEC [NV] = '{
    {5'b11000, 4'd5},  // deselected idle
    {5'b01001, 4'd4},  // selected, driving allowed
    {5'b00010, 4'd1},  // R1: pause with clock low
    {5'b00110, 4'd4},  // R4: clock high while paused
    {5'b01110, 4'd3},  // R3: release with clock high waits
    {5'b01001, 4'd3},  // R3: clock low ends pause
    {5'b01101, 4'd4},
    {5'b00101, 4'd2},  // R2: pause with clock high waits
    {5'b00010, 4'd2},  // R2: clock low starts pause
    {5'b01001, 4'd3},  // R3: release with clock low
    {5'b00010, 4'd1},
    {5'b10000, 4'd5},  // R5: deselect clears pause
    {5'b00010, 4'd6},  // R6: select with pause low, clock low
    {5'b10100, 4'd5},
    {5'b00101, 4'd6},  // R6: select with pause low, clock high
    {5'b00010, 4'd6},
    {5'b11000, 4'd5}
  };

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic h, input logic s);
    @(negedge clk);
    cs_n = c; hold_n = h; sck = s;
    settle();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(cs_n, hold_n, 1'b1);
      drive(cs_n, hold_n, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int r0, f0, a0;
    repeat (4) @(negedge clk);
    chk("R9 reset hold", int'(hold_active), 0);
    chk("R9 reset oe", int'(so_oe), 0);
    rst = 1'b0;
    settle();
    chk("R9 idle hold", int'(hold_active), 0);
    chk("R9 idle strobes", int'(sck_rise | sck_fall | hold_abort), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8], VEC[i][7], VEC[i][6]);
      chk($sformatf("R%0d vec %0d hold", VEC[i][3:0], i), int'(hold_active), int'(VEC[i][5]));
      chk($sformatf("R%0d vec %0d oe", VEC[i][3:0], i), int'(so_oe), int'(VEC[i][4]));
    end

    // R7: edges pass while running, none while paused
    drive(1'b0, 1'b1, 1'b0);
    r0 = n_rise; f0 = n_fall;
    toggle(4);
    chk("R7 run rises", n_rise - r0, 4);
    chk("R7 run falls", n_fall - f0, 4);
    drive(1'b0, 1'b0, 1'b0);
    r0 = n_rise; f0 = n_fall;
    toggle(3);
    chk("R7 paused rises", n_rise - r0, 0);
    chk("R7 paused falls", n_fall - f0, 0);
    chk("R4 paused oe", int'(so_oe), 0);
    drive(1'b0, 1'b1, 1'b0);
    r0 = n_rise; f0 = n_fall;
    toggle(1);
    chk("R7 resumed rises", n_rise - r0, 1);
    chk("R7 resumed falls", n_fall - f0, 1);

    // R8: the falling edge that starts or ends a pause is swallowed
    r0 = n_rise; f0 = n_fall;
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R8 entry hold", int'(hold_active), 1);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    chk("R8 exit hold", int'(hold_active), 0);
    chk("R8 rises across pause", n_rise - r0, 1);
    chk("R8 falls across pause", n_fall - f0, 0);
    drive(1'b0, 1'b1, 1'b1);
    chk("R8 next rise passes", n_rise - r0, 2);
    drive(1'b0, 1'b1, 1'b0);

    // R5: abort strobe only for deselect during a pause
    drive(1'b0, 1'b0, 1'b0);
    a0 = n_abort;
    drive(1'b1, 1'b0, 1'b0);
    chk("R5 abort count", n_abort - a0, 1);
    chk("R5 cleared hold", int'(hold_active), 0);
    drive(1'b0, 1'b1, 1'b0);
    a0 = n_abort;
    drive(1'b1, 1'b1, 1'b0);
    chk("R5 no abort outside pause", n_abort - a0, 0);

    // R9: reset in the middle of a pause
    drive(1'b0, 1'b0, 1'b0);
    chk("R9 pre-reset hold", int'(hold_active), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R9 mid reset hold", int'(hold_active), 0);
    chk("R9 mid reset oe", int'(so_oe), 0);
    rst = 1'b0;
    settle();
    chk("R1 pause after reset", int'(hold_active), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule